// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of an asynchronous DRAM module inside its retention window. A free-running timer counts a fixed number of clock cycles per refresh slot. Each slot adds one to a count of refreshes owed. While anything is owed, the block asks the access controller for the bus with `rq_o`. When the controller answers with `gnt_i`, the block owns the strobes for one complete refresh cycle.

Two refresh methods are offered. The choice is made per cycle, when the grant is taken. In CAS-before-RAS mode the column strobe falls first and the memory steps its own row counter. In RAS-only mode the column strobe stays high, and the block drives an 11-bit row address from its own counter. The owed count saturates. Above a threshold it raises an urgent flag, so the controller ends an open page burst and lets the backlog drain before the deadline. After reset, a fixed batch of initial refresh cycles is served before normal accesses are allowed.

Top module: `dram_refresh_sched`

## Requirements
- R1: Once reset is released, a refresh slot elapses every `TICK_CYCLES` clock cycles. Each slot adds one to the owed count, unless a grant taken in the same cycle removes one.
- R2: `rq_o` is high exactly when no refresh cycle is in progress and either initial or owed refreshes remain. A `gnt_i` seen while `rq_o` is low is ignored.
- R3: The owed count saturates at 2^`OWED_W`-1 and never wraps to zero.
- R4: `urgent_o` is high exactly when the owed count is at least `URGENT_AT`.
- R5: After reset, `INIT_REFRESHES` grants are served as initial refreshes, and they do not reduce the owed count. `init_done_o` is low until the last of them is granted, and it then stays high until the next reset.
- R6: CAS-before-RAS cycle (mode input 0 at grant). The grant is taken on a clock edge, and the cycle lasts `T_LEAD+T_RAS+T_PRE` cycles after that edge. `cas_n_o` is low from the first cycle. `ras_n_o` is low from cycle `T_LEAD` to cycle `T_LEAD+T_RAS-1`. Both strobes rise together and stay high for the last `T_PRE` cycles. `addr_oe_o` stays low.
- R7: RAS-only cycle (mode input 1 at grant). The window of `ras_n_o` and the cycle length are the same as in R6. `cas_n_o` stays high, and `addr_oe_o` is high for the whole cycle.
- R8: `row_o` increments by one at the end of each RAS-only cycle and wraps from 2047 to 0. A CAS-before-RAS cycle leaves `row_o` unchanged.
- R9: The mode input is sampled only on the grant edge. A change to it during a cycle in progress has no effect on that cycle.
- R10: While reset is active, the block holds both strobes high, `busy_o`, `urgent_o`, `addr_oe_o` and `init_done_o` low, and `row_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only_i | input | 1 | Refresh method: 1 = RAS-only, 0 = CAS-before-RAS |
| gnt_i | input | 1 | Bus grant from the access controller |
| rq_o | output | 1 | Refresh request to the access controller |
| urgent_o | output | 1 | Backlog above threshold; the open page must be closed |
| init_done_o | output | 1 | Initial refresh batch complete |
| busy_o | output | 1 | Refresh cycle in progress; the block owns the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_oe_o | output | 1 | Row address is driven onto the address bus |
| row_o | output | ROW_W | Refresh row address for RAS-only mode |

## Verification
The bench first holds the grant high continuously. This separates the back-to-back initial batch from the timer-paced steady state. It then withholds the grant for many slots, which pushes the owed count through the urgent threshold and into saturation. A second run at full rate in RAS-only mode carries the row counter through its wrap. A final phase varies the grant and the mode pattern from cycle to cycle. It flips the mode in the middle of cycles and offers grants while no request is pending, which tells a mode sampled at the grant apart from a mode followed live, and a grant that is ignored apart from one that is honoured.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int TICK_CYCLES    = 1900,
  parameter int ROW_W          = 11,
  parameter int OWED_W         = 4,
  parameter int URGENT_AT      = 8,
  parameter int INIT_REFRESHES = 8,
  parameter int T_LEAD         = 2,
  parameter int T_RAS          = 7,
  parameter int T_PRE          = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_i,
  input  logic             gnt_i,
  output logic             rq_o,
  output logic             urgent_o,
  output logic             init_done_o,
  output logic             busy_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             addr_oe_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int T_TOT  = T_LEAD + T_RAS + T_PRE;
  localparam int TMR_W  = $clog2(TICK_CYCLES + 1);
  localparam int STEP_W = $clog2(T_TOT + 1);
  localparam int INIT_W = $clog2(INIT_REFRESHES + 1);
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(TICK_CYCLES - 1);
  localparam logic [STEP_W-1:0] RAS_ON   = STEP_W'(T_LEAD);
  localparam logic [STEP_W-1:0] RAS_OFF  = STEP_W'(T_LEAD + T_RAS);
  localparam logic [STEP_W-1:0] STEP_END = STEP_W'(T_TOT - 1);
  localparam logic [OWED_W-1:0] OWED_MAX = '1;
  localparam logic [OWED_W-1:0] URG_LVL  = OWED_W'(URGENT_AT);

  logic [TMR_W-1:0]  tmr;
  logic [OWED_W-1:0] owed;
  logic [INIT_W-1:0] init_left;
  logic [STEP_W-1:0] step;
  logic              mode_q;

  wire tick      = (tmr == TMR_LAST);
  wire from_init = (init_left != '0);
  wire take      = rq_o && gnt_i;
  wire dec       = take && !from_init;
  wire last      = busy_o && (step == STEP_END);

  assign rq_o        = !busy_o && (from_init || owed != '0);
  assign urgent_o    = (owed >= URG_LVL);
  assign init_done_o = !from_init && rst_n;
  assign ras_n_o     = !(busy_o && step >= RAS_ON && step < RAS_OFF);
  assign cas_n_o     = !(busy_o && !mode_q && step < RAS_OFF);
  assign addr_oe_o   = busy_o && mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= tick ? '0 : tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      owed <= '0;
    else if (tick && !dec && owed != OWED_MAX)
      owed <= owed + 1'b1;
    else if (!tick && dec)
      owed <= owed - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 init_left <= INIT_W'(INIT_REFRESHES);
    else if (take && from_init) init_left <= init_left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      step   <= '0;
      mode_q <= 1'b0;
      row_o  <= '0;
    end else if (take) begin
      busy_o <= 1'b1;
      step   <= '0;
      mode_q <= ras_only_i;
    end else if (last) begin
      busy_o <= 1'b0;
      if (mode_q) row_o <= row_o + 1'b1;
    end else if (busy_o) begin
      step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rq_o,
  input logic             busy_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             addr_oe_o,
  input logic             init_done_o,
  input logic [ROW_W-1:0] row_o
);
  assert_idle_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (ras_n_o && cas_n_o));

  assert_no_cas_ras_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe_o |-> cas_n_o);

  assert_cas_before_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n_o) && !addr_oe_o) |-> !cas_n_o);

  assert_no_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !rq_o);

  assert_row_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && $past(addr_oe_o)) |-> (row_o == ROW_W'($past(row_o) + 1'b1)));

  assert_row_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe_o |=> (row_o == $past(row_o)));

  assert_init_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rq_o(rq_o), .busy_o(busy_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .addr_oe_o(addr_oe_o), .init_done_o(init_done_o), .row_o(row_o)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb_top;
  localparam int TICK = 16, ROW_W = 11, OWED_W = 4, URG = 8, INIT = 8;
  localparam int TL = 2, TR = 7, TP = 5, TOT = TL + TR + TP, OMAX = (1 << OWED_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, gnt = 1'b0;
  logic rq, urg, idone, busy, ras_n, cas_n, aoe;
  logic [ROW_W-1:0] row;
  int checks = 0, fails = 0, cyc = 0;
  bit wrap_seen = 0;

  always #4 clk = ~clk;

  dram_refresh_sched #(.TICK_CYCLES(TICK), .ROW_W(ROW_W), .OWED_W(OWED_W), .URGENT_AT(URG),
    .INIT_REFRESHES(INIT), .T_LEAD(TL), .T_RAS(TR), .T_PRE(TP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_only_i(mode), .gnt_i(gnt), .rq_o(rq), .urgent_o(urg),
    .init_done_o(idone), .busy_o(busy), .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_oe_o(aoe),
    .row_o(row));

  int m_tmr, m_owed, m_init, m_busy, m_step, m_mode, m_row;

  function automatic bit m_req();
    return (m_busy == 0) && (m_owed > 0 || m_init > 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr = 0; m_owed = 0; m_init = INIT; m_busy = 0; m_step = 0; m_mode = 0; m_row = 0;
    end else begin
      bit tick, take;
      int d;
      tick = (m_tmr == TICK - 1);
      m_tmr = tick ? 0 : m_tmr + 1;
      take = m_req() && gnt;
      d = 0;
      if (take) begin
        if (m_init > 0) m_init--; else d = 1;
        m_busy = 1; m_step = 0; m_mode = mode;
      end else if (m_busy == 1) begin
        if (m_step == TOT - 1) begin
          m_busy = 0;
          if (m_mode == 1) begin
            if (m_row == 2047) wrap_seen = 1;
            m_row = (m_row + 1) % 2048;
          end
        end else m_step++;
      end
      m_owed = m_owed + (tick ? 1 : 0) - d;
      if (m_owed > OMAX) m_owed = OMAX;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit exp_ras, exp_cas;
    cyc++;
    exp_ras = !(m_busy == 1 && m_step >= TL && m_step < TL + TR);
    exp_cas = !(m_busy == 1 && m_mode == 0 && m_step < TL + TR);
    chk("R2 rq", rq, m_req());
    chk("R4 urgent", urg, (rst_n && m_owed >= URG) ? 1 : 0);
    chk("R5 init_done", idone, (rst_n && m_init == 0) ? 1 : 0);
    chk("R6 busy", busy, m_busy);
    chk("R6 ras_n", ras_n, exp_ras);
    chk("R9 cas_n", cas_n, exp_cas);
    chk("R7 addr_oe", aoe, (m_busy == 1 && m_mode == 1) ? 1 : 0);
    chk("R8 row", row, m_row);
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 ras_n", ras_n, 1); chk("R10 cas_n", cas_n, 1); chk("R10 busy", busy, 0);
    chk("R10 row", row, 0); chk("R10 init_done", idone, 0); chk("R10 urgent", urg, 0);
    rst_n = 1'b1;
    // R5/R6: continuous grant, CBR, init batch back to back
    gnt = 1'b1;
    repeat (INIT * TOT + 4) @(negedge clk);
    chk("R5 init done after batch", idone, 1);
    repeat (300) @(negedge clk);
    // R1/R3/R4: withhold grant until saturation
    gnt = 1'b0;
    repeat (TICK * (OMAX + 6)) @(negedge clk);
    chk("R3 saturated owed", m_owed, OMAX);
    chk("R4 urgent at saturation", urg, 1);
    // R7/R8: RAS-only at full rate until wrap
    mode = 1'b1; gnt = 1'b1;
    repeat (2060 * TICK) @(negedge clk);
    chk("R8 wrap seen", wrap_seen, 1);
    // R2/R9: varied grant and mode pattern
    for (int i = 0; i < 3000; i++) begin
      gnt  = ((i * 7) % 5) < 2;
      mode = ((i * 3) % 11) < 5;
      @(negedge clk);
    end
    gnt = 1'b0;
    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule